// File: doc/BRIEF.md
# Trip-Threshold Programming Sequencer

This block watches a decoded two-wire serial bus and picks out one special write command. That command commits a supply-monitor trip threshold for one of three monitored channels. The bus front end gives it single-cycle event pulses: a start condition, a stop condition, and a received byte along with its value. A separate digital flag reports whether the high-voltage programming level is present on the watchdog output pin.

A command is accepted only when all of the following hold:
- The flag is already high when the start condition arrives.
- The first byte is the write slave address.
- The second byte is a valid channel code.
- The third byte is the zero data value.

The stop condition that follows launches the commit. The block then holds a one-hot program strobe for the chosen channel until the flag drops, and reports completion with a one-cycle done pulse. The block aborts back to idle with no strobe in any of these cases:
- A byte does not match what the sequence expects.
- The flag drops part way through.
- The stop arrives early.
- An extra byte arrives after the data byte.

A repeated start restarts the check from the slave address.

Top module: `trip_prog_seq`

## Requirements
- R1: While `rst_n` is low, `prog_strobe`, `ack_req` and `prog_done` are all 0, whatever the bus inputs do.
- R2: A start pulse is accepted only if `hv_flag` is 1 in the same cycle. After a start seen with `hv_flag` at 0, no byte is acknowledged until a start arrives with the flag high.
- R3: After an accepted start, the first byte must equal 8'hA0. An accepted byte raises `ack_req` for exactly one cycle, in the cycle after the byte pulse.
- R4: The second byte selects the channel. 8'h01 selects channel 1 (`prog_strobe` bit 0), 8'h09 selects channel 2 (bit 1) and 8'h0D selects channel 3 (bit 2).
- R5: The third byte must equal 8'h00. Any other value gets no acknowledge and aborts the sequence.
- R6: A stop pulse that directly follows an accepted data byte sets `prog_strobe` to the one-hot code of the selected channel in the next cycle. The strobe stays at that value while `hv_flag` stays 1, and bus events are ignored meanwhile.
- R7: While the strobe is held, a cycle with `hv_flag` at 0 clears `prog_strobe` in the next cycle. In that same cycle `prog_done` is 1 for exactly one cycle.
- R8: A byte that does not match the expected value is not acknowledged and returns the block to idle. Later bytes are not acknowledged before a new start.
- R9: If `hv_flag` goes to 0 at any point between an accepted start and the stop, the sequence aborts. No further byte is acknowledged and no strobe follows.
- R10: A start pulse in the middle of a sequence restarts it. The next byte is checked as the slave address.
- R11: A stop before the data byte is accepted aborts with no strobe. So does an extra byte after the data byte, and that byte gets no acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_start | input | 1 | One-cycle pulse for a bus start condition |
| ev_stop | input | 1 | One-cycle pulse for a bus stop condition |
| ev_byte | input | 1 | One-cycle pulse for a received byte |
| byte_data | input | 8 | Value of the received byte, valid with `ev_byte` |
| hv_flag | input | 1 | 1 while the programming voltage is present |
| ack_req | output | 1 | One-cycle request to acknowledge an accepted byte |
| prog_strobe | output | 3 | One-hot commit strobe per channel |
| prog_done | output | 1 | One-cycle pulse when the commit finishes |

## Verification
The bench builds the block with its default parameters: an 8-bit byte, three channels, slave address A0h, data value 00h and channel codes 01h, 09h and 0Dh. These values bring every state of the sequence within reach, together with every abort path and the strobe for each of the three channels. Scoreboard items are written from the requirement text: an acknowledge per accepted byte, a strobe pattern as a shifted one, and a done pulse when the flag falls.

// File: rtl/trip_prog_pkg.sv
`timescale 1ns/1ps
package trip_prog_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE    = 3'd0,
    SQ_ADDR    = 3'd1,
    SQ_REG     = 3'd2,
    SQ_DATA    = 3'd3,
    SQ_STOP    = 3'd4,
    SQ_PROGRAM = 3'd5
  } seq_state_t;

  // Wait state that follows an accepted byte in a given wait state.
  function automatic seq_state_t seq_advance(input seq_state_t st);
    case (st)
      SQ_ADDR: return SQ_REG;
      SQ_REG:  return SQ_DATA;
      SQ_DATA: return SQ_STOP;
      default: return SQ_IDLE;
    endcase
  endfunction

  // True for states where the bus sequence is still being collected.
  function automatic logic seq_collecting(input seq_state_t st);
    return (st == SQ_ADDR) || (st == SQ_REG) || (st == SQ_DATA) || (st == SQ_STOP);
  endfunction

  // Field compare, kept as a function so the bench can restate it.
  function automatic logic byte_equals(input logic [7:0] a, input logic [7:0] b);
    return a == b;
  endfunction

endpackage

// File: rtl/tp_byte_decoder.sv
`timescale 1ns/1ps
module tp_byte_decoder #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned NUM_CH = 3,
  parameter logic [BYTE_W-1:0] SLAVE_ADDR = 8'hA0,
  parameter logic [BYTE_W-1:0] DATA_VAL = 8'h00,
  parameter logic [NUM_CH*BYTE_W-1:0] CH_CODES = 24'h0D0901
) (
  input  logic [BYTE_W-1:0] byte_data,
  output logic              is_addr,
  output logic              is_data,
  output logic [NUM_CH-1:0] chan_hit,
  output logic              any_chan
);
  import trip_prog_pkg::*;

  assign is_addr = byte_equals(byte_data, SLAVE_ADDR);
  assign is_data = byte_equals(byte_data, DATA_VAL);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    localparam logic [BYTE_W-1:0] CODE = CH_CODES[g*BYTE_W +: BYTE_W];
    assign chan_hit[g] = byte_equals(byte_data, CODE);
  end

  assign any_chan = |chan_hit;

  // R4
  chan_hit_unique_chk: assert final ($onehot0(chan_hit));
endmodule

// File: rtl/tp_seq_fsm.sv
`timescale 1ns/1ps
module tp_seq_fsm #(
  parameter int unsigned NUM_CH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_start,
  input  logic              ev_stop,
  input  logic              ev_byte,
  input  logic              hv_flag,
  input  logic              is_addr,
  input  logic              is_data,
  input  logic [NUM_CH-1:0] chan_hit,
  input  logic              any_chan,
  output logic              in_program,
  output logic [NUM_CH-1:0] sel_ch,
  output logic              ack_req,
  output logic              prog_done
);
  import trip_prog_pkg::*;

  seq_state_t st_q, st_d;
  logic       ack_d, done_d;
  logic       byte_ok;
  logic       load_sel;
  logic       abort_ev;

  always_comb begin
    case (st_q)
      SQ_ADDR: byte_ok = is_addr;
      SQ_REG:  byte_ok = any_chan;
      SQ_DATA: byte_ok = is_data;
      default: byte_ok = 1'b0;
    endcase
  end

  always_comb begin
    st_d     = st_q;
    ack_d    = 1'b0;
    done_d   = 1'b0;
    abort_ev = 1'b0;
    if (st_q == SQ_IDLE) begin
      if (ev_start && hv_flag) st_d = SQ_ADDR;
    end else if (seq_collecting(st_q)) begin
      if (!hv_flag) begin
        st_d     = SQ_IDLE;
        abort_ev = 1'b1;
      end else if (ev_start) begin
        st_d = SQ_ADDR;
      end else if (ev_stop) begin
        if (st_q == SQ_STOP) begin
          st_d = SQ_PROGRAM;
        end else begin
          st_d     = SQ_IDLE;
          abort_ev = 1'b1;
        end
      end else if (ev_byte) begin
        if (byte_ok) begin
          st_d  = seq_advance(st_q);
          ack_d = 1'b1;
        end else begin
          st_d     = SQ_IDLE;
          abort_ev = 1'b1;
        end
      end
    end else if (st_q == SQ_PROGRAM) begin
      if (!hv_flag) begin
        st_d   = SQ_IDLE;
        done_d = 1'b1;
      end
    end else begin
      st_d = SQ_IDLE;
    end
  end

  assign load_sel = ack_d && (st_q == SQ_REG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= SQ_IDLE;
      ack_req   <= 1'b0;
      prog_done <= 1'b0;
      sel_ch    <= '0;
    end else begin
      st_q      <= st_d;
      ack_req   <= ack_d;
      prog_done <= done_d;
      if (load_sel) sel_ch <= chan_hit;
    end
  end

  assign in_program = (st_q == SQ_PROGRAM);

  // R3
  ack_needs_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req |-> $past(ev_byte));
  // R6
  program_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_program) |-> $past(ev_stop));
  // R7
  done_after_program_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_done |-> ($past(in_program) && !in_program));
  // R9
  abort_goes_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_ev |=> (st_q == SQ_IDLE));
endmodule

// File: rtl/tp_strobe_drv.sv
`timescale 1ns/1ps
module tp_strobe_drv #(
  parameter int unsigned NUM_CH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_program,
  input  logic              hv_flag,
  input  logic [NUM_CH-1:0] sel_ch,
  output logic [NUM_CH-1:0] prog_strobe
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_stb
    assign prog_strobe[g] = in_program & sel_ch[g];
  end

  // R4
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(prog_strobe));
  // R6
  strobe_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|prog_strobe) && hv_flag) |=> $stable(prog_strobe));
endmodule

// File: rtl/trip_prog_seq.sv
`timescale 1ns/1ps
module trip_prog_seq #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned NUM_CH = 3,
  parameter logic [BYTE_W-1:0] SLAVE_ADDR = 8'hA0,
  parameter logic [BYTE_W-1:0] DATA_VAL = 8'h00,
  parameter logic [NUM_CH*BYTE_W-1:0] CH_CODES = 24'h0D0901
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_start,
  input  logic              ev_stop,
  input  logic              ev_byte,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic              hv_flag,
  output logic              ack_req,
  output logic [NUM_CH-1:0] prog_strobe,
  output logic              prog_done
);
  logic              is_addr, is_data, any_chan, in_program;
  logic [NUM_CH-1:0] chan_hit, sel_ch;

  tp_byte_decoder #(
    .BYTE_W(BYTE_W), .NUM_CH(NUM_CH), .SLAVE_ADDR(SLAVE_ADDR),
    .DATA_VAL(DATA_VAL), .CH_CODES(CH_CODES)
  ) u_dec (
    .byte_data(byte_data), .is_addr(is_addr), .is_data(is_data),
    .chan_hit(chan_hit), .any_chan(any_chan)
  );

  tp_seq_fsm #(.NUM_CH(NUM_CH)) u_fsm (
    .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_stop(ev_stop),
    .ev_byte(ev_byte), .hv_flag(hv_flag), .is_addr(is_addr),
    .is_data(is_data), .chan_hit(chan_hit), .any_chan(any_chan),
    .in_program(in_program), .sel_ch(sel_ch), .ack_req(ack_req),
    .prog_done(prog_done)
  );

  tp_strobe_drv #(.NUM_CH(NUM_CH)) u_stb (
    .clk(clk), .rst_n(rst_n), .in_program(in_program), .hv_flag(hv_flag),
    .sel_ch(sel_ch), .prog_strobe(prog_strobe)
  );

  // R7
  done_strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(prog_done && (|prog_strobe)));
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (!ack_req && !prog_done && prog_strobe == '0));
endmodule

// File: tb/sim_trip_prog_seq.sv
`timescale 1ns/1ps
module sim_trip_prog_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ev_start = 1'b0, ev_stop = 1'b0, ev_byte = 1'b0, hv_flag = 1'b0;
  logic [7:0] byte_data = 8'h00;
  logic       ack_req, prog_done;
  logic [2:0] prog_strobe;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  typedef struct {
    logic       ack;
    logic [2:0] stb;
    logic       done;
    string      req;
  } exp_t;
  exp_t exp_q[$];

  always #2.5 clk = ~clk;

  trip_prog_seq u0 (
    .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_stop(ev_stop),
    .ev_byte(ev_byte), .byte_data(byte_data), .hv_flag(hv_flag),
    .ack_req(ack_req), .prog_strobe(prog_strobe), .prog_done(prog_done)
  );

  function automatic logic [7:0] code_of(input int ch);
    if (ch == 1) return 8'h01;
    if (ch == 2) return 8'h09;
    return 8'h0D;
  endfunction

  function automatic logic [2:0] stb_of(input int ch);
    return 3'(1 << (ch - 1));
  endfunction

  // Driver: applies one cycle of inputs and queues the expected outputs
  task automatic step(input logic s, input logic p, input logic b,
                      input logic [7:0] d, input logic f,
                      input logic ea, input logic [2:0] es, input logic ed,
                      input string r);
    exp_t e;
    @(negedge clk);
    ev_start = s; ev_stop = p; ev_byte = b; byte_data = d; hv_flag = f;
    e.ack = ea; e.stb = es; e.done = ed; e.req = r;
    exp_q.push_back(e);
  endtask

  // Monitor: compares design outputs after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        checks++;
        if (ack_req !== e.ack || prog_strobe !== e.stb || prog_done !== e.done) begin
          failures++;
          $display("FAIL %s: ack=%b stb=%b done=%b expected ack=%b stb=%b done=%b",
                   e.req, ack_req, prog_strobe, prog_done, e.ack, e.stb, e.done);
        end
      end
    end
  end

  task automatic full_program(input int ch, input string r);
    step(0,0,0,8'h00,1, 0,3'b000,0, r);
    step(1,0,0,8'h00,1, 0,3'b000,0, r);
    step(0,0,1,8'hA0,1, 1,3'b000,0, "R3");
    step(0,0,1,code_of(ch),1, 1,3'b000,0, "R4");
    step(0,0,1,8'h00,1, 1,3'b000,0, "R5");
    step(0,1,0,8'h00,1, 0,stb_of(ch),0, "R6");
    step(0,0,1,8'hA0,1, 0,stb_of(ch),0, "R6");
    step(1,0,0,8'h00,1, 0,stb_of(ch),0, "R6");
    step(0,0,0,8'h00,0, 0,3'b000,1, "R7");
    step(0,0,0,8'h00,0, 0,3'b000,0, "R7");
  endtask

  initial begin
    // R1: reset holds outputs quiet under bus activity
    step(1,0,0,8'h00,1, 0,3'b000,0, "R1");
    step(0,0,1,8'hA0,1, 0,3'b000,0, "R1");
    step(0,1,0,8'h00,1, 0,3'b000,0, "R1");
    @(negedge clk); rst_n = 1'b1;

    full_program(1, "R4");
    full_program(2, "R4");
    full_program(3, "R4");

    // R2: start without the flag is ignored
    step(1,0,0,8'h00,0, 0,3'b000,0, "R2");
    step(0,0,1,8'hA0,1, 0,3'b000,0, "R2");
    step(0,0,1,8'h01,1, 0,3'b000,0, "R2");
    step(0,1,0,8'h00,1, 0,3'b000,0, "R2");

    // R8: wrong slave address, later bytes not acknowledged
    step(1,0,0,8'h00,1, 0,3'b000,0, "R8");
    step(0,0,1,8'hA1,1, 0,3'b000,0, "R8");
    step(0,0,1,8'h01,1, 0,3'b000,0, "R8");
    step(0,0,1,8'h00,1, 0,3'b000,0, "R8");
    step(0,1,0,8'h00,1, 0,3'b000,0, "R8");
    // R8: unknown channel code
    step(1,0,0,8'h00,1, 0,3'b000,0, "R8");
    step(0,0,1,8'hA0,1, 1,3'b000,0, "R8");
    step(0,0,1,8'h05,1, 0,3'b000,0, "R8");
    step(0,0,1,8'h00,1, 0,3'b000,0, "R8");
    step(0,1,0,8'h00,1, 0,3'b000,0, "R8");

    // R5: non-zero data byte
    step(1,0,0,8'h00,1, 0,3'b000,0, "R5");
    step(0,0,1,8'hA0,1, 1,3'b000,0, "R5");
    step(0,0,1,8'h09,1, 1,3'b000,0, "R5");
    step(0,0,1,8'h01,1, 0,3'b000,0, "R5");
    step(0,1,0,8'h00,1, 0,3'b000,0, "R5");

    // R9: flag drops mid sequence
    step(1,0,0,8'h00,1, 0,3'b000,0, "R9");
    step(0,0,1,8'hA0,1, 1,3'b000,0, "R9");
    step(0,0,1,8'h01,1, 1,3'b000,0, "R9");
    step(0,0,0,8'h00,0, 0,3'b000,0, "R9");
    step(0,0,1,8'h00,1, 0,3'b000,0, "R9");
    step(0,1,0,8'h00,1, 0,3'b000,0, "R9");

    // R10: repeated start restarts from the address
    step(1,0,0,8'h00,1, 0,3'b000,0, "R10");
    step(0,0,1,8'hA0,1, 1,3'b000,0, "R10");
    step(1,0,0,8'h00,1, 0,3'b000,0, "R10");
    step(0,0,1,8'h09,1, 0,3'b000,0, "R10");
    step(1,0,0,8'h00,1, 0,3'b000,0, "R10");
    step(0,0,1,8'hA0,1, 1,3'b000,0, "R10");
    step(0,0,1,8'h09,1, 1,3'b000,0, "R10");
    step(0,0,1,8'h00,1, 1,3'b000,0, "R10");
    step(0,1,0,8'h00,1, 0,3'b010,0, "R10");
    step(0,0,0,8'h00,0, 0,3'b000,1, "R10");

    // R11: early stop, then an extra byte after data
    step(1,0,0,8'h00,1, 0,3'b000,0, "R11");
    step(0,0,1,8'hA0,1, 1,3'b000,0, "R11");
    step(0,0,1,8'h0D,1, 1,3'b000,0, "R11");
    step(0,1,0,8'h00,1, 0,3'b000,0, "R11");
    step(0,0,1,8'h00,1, 0,3'b000,0, "R11");
    step(1,0,0,8'h00,1, 0,3'b000,0, "R11");
    step(0,0,1,8'hA0,1, 1,3'b000,0, "R11");
    step(0,0,1,8'h0D,1, 1,3'b000,0, "R11");
    step(0,0,1,8'h00,1, 1,3'b000,0, "R11");
    step(0,0,1,8'h00,1, 0,3'b000,0, "R11");
    step(0,1,0,8'h00,1, 0,3'b000,0, "R11");
    step(0,0,0,8'h00,0, 0,3'b000,0, "R11");

    @(negedge clk);
    ev_start = 0; ev_stop = 0; ev_byte = 0;
    @(negedge clk);
    @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule